// File: doc/BRIEF.md
# Compact Branch Target Generator

This block computes the program counter, link value and execution-mode updates for every branch form of a 16-bit instruction set. It is purely combinational. A decode stage supplies the instruction halfword, the pipelined PC (the value already ahead of the executing instruction), the current link register, the value of the register named as the indirect target, and a pass signal from the condition evaluator. The surrounding core latches the results when the matching write enables are high. The block evaluates no condition codes and flushes no pipeline.

A long call is split across two halfwords. The first halfword places the upper part of the displacement, relative to PC, in the link register. The second halfword adds the lower part to that link value to form the target, and it leaves a return address with bit 0 set in the link register. The indirect branch takes the new execution mode from bit 0 of its target register. When its source register is the PC, it also clears bit 1 so that the target is word aligned.

Top module: `compact_branch_gen`

## Requirements
- R1: A conditional branch (insn[15:12] = 4'hD, insn[11:9] not 3'b111) with cond_pass_i = 1 writes pc_o = pc_i + 2 × sign-extended insn[7:0], with pc_we_o = 1 and lr_we_o = 0.
- R2: A conditional branch with cond_pass_i = 0, and any halfword with insn[15:12] = 4'hD and insn[11:9] = 3'b111, raises no write enable. With no enable raised, pc_o equals pc_i and lr_o equals lr_i.
- R3: An unconditional branch (insn[15:11] = 5'b11100) writes pc_o = pc_i + 2 × sign-extended insn[10:0] and does not write the link.
- R4: The first call halfword (insn[15:11] = 5'b11110) writes lr_o = pc_i + (sign-extended insn[10:0] shifted left by 12) and leaves pc_we_o low.
- R5: The second call halfword (insn[15:11] = 5'b11111) writes pc_o = lr_i + 2 × zero-extended insn[10:0] and lr_o = pc_i − 1. Both enables are high.
- R6: The indirect branch (insn[15:7] = 9'b010001110, source register number in insn[6:3]) writes pc_o = rm_val_i with bit 0 cleared, mode_o = rm_val_i[0] and mode_we_o = 1.
- R7: When the indirect branch source register number is 15 (the PC), pc_o also has bit 1 cleared.
- R8: mode_we_o is high only for the indirect branch. Any halfword that is not a branch form raises no enable. mode_o is 0 whenever mode_we_o is 0.
- R9: All sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Pipelined program counter |
| lr_i | input | 32 | Current link register |
| rm_val_i | input | 32 | Value of the indirect target register |
| insn_i | input | 16 | Instruction halfword |
| cond_pass_i | input | 1 | Condition evaluated true |
| pc_o | output | 32 | Next PC (equals pc_i when not written) |
| pc_we_o | output | 1 | PC write enable |
| lr_o | output | 32 | Next link value (equals lr_i when not written) |
| lr_we_o | output | 1 | Link write enable |
| mode_o | output | 1 | New execution mode |
| mode_we_o | output | 1 | Mode write enable |

## Verification
The hardest case to reach is the indirect branch with the PC as its own source, with both low bits of the operand set. Only that combination shows the extra alignment, separately from the mode extraction. Because the block receives the operand value as an input, the stimulus encodes register number 15 in the halfword and supplies operands ending in 2'b11 and 2'b10. It then compares these results against the same operands under a low register number. Wrap-around is reached by placing the PC and link near the top and bottom of the address space and using negative and maximum displacements.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  localparam int INSN_W = 16;
  localparam int FIELD_W = 11;
  localparam int SHORT_W = 8;
  localparam int RIDX_W = 4;
  localparam logic [RIDX_W-1:0] PC_REG_IDX = 4'hF;

  typedef enum logic [2:0] {
    BK_NONE     = 3'd0,
    BK_COND     = 3'd1,
    BK_JUMP     = 3'd2,
    BK_CALL_HI  = 3'd3,
    BK_CALL_LO  = 3'd4,
    BK_INDIRECT = 3'd5
  } br_kind_e;
endpackage

// File: rtl/cbt_decode.sv
module cbt_decode
  import cbt_pkg::*;
(
  input  logic [INSN_W-1:3] op_hi,
  input  logic              cond_ok,
  output br_kind_e          kind,
  output logic              src_is_pc
);
  logic is_cond_grp;
  logic cond_reserved;

  assign is_cond_grp   = (op_hi[15:12] == 4'hD);
  assign cond_reserved = (op_hi[11:9] == 3'b111);
  assign src_is_pc     = (op_hi[6:3] == PC_REG_IDX);

  always_comb begin
    kind = BK_NONE;
    if (is_cond_grp) begin
      if (!cond_reserved && cond_ok) kind = BK_COND;
    end else if (op_hi[15:7] == 9'b010001110) begin
      kind = BK_INDIRECT;
    end else begin
      case (op_hi[15:11])
        5'b11100: kind = BK_JUMP;
        5'b11110: kind = BK_CALL_HI;
        5'b11111: kind = BK_CALL_LO;
        default:  kind = BK_NONE;
      endcase
    end
  end
endmodule

// File: rtl/cbt_target.sv
module cbt_target
  import cbt_pkg::*;
#(
  parameter int XLEN = 32,
  parameter bit ALIGN_PC_SRC = 1'b1
) (
  input  br_kind_e           kind,
  input  logic               src_is_pc,
  input  logic [FIELD_W-1:0] field,
  input  logic [XLEN-1:0]    pc,
  input  logic [XLEN-1:0]    lr,
  input  logic [XLEN-1:0]    rm_val,
  output logic [XLEN-1:0]    pc_n,
  output logic               pc_we,
  output logic [XLEN-1:0]    lr_n,
  output logic               lr_we,
  output logic               mode,
  output logic               mode_we
);
  localparam int HI_SHIFT = FIELD_W + 1;

  function automatic logic [XLEN-1:0] off_short(input logic [SHORT_W-1:0] f);
    return {{(XLEN-SHORT_W-1){f[SHORT_W-1]}}, f, 1'b0};
  endfunction

  function automatic logic [XLEN-1:0] off_jump(input logic [FIELD_W-1:0] f);
    return {{(XLEN-FIELD_W-1){f[FIELD_W-1]}}, f, 1'b0};
  endfunction

  function automatic logic [XLEN-1:0] off_call_hi(input logic [FIELD_W-1:0] f);
    return {{(XLEN-FIELD_W-HI_SHIFT){f[FIELD_W-1]}}, f, {HI_SHIFT{1'b0}}};
  endfunction

  function automatic logic [XLEN-1:0] off_call_lo(input logic [FIELD_W-1:0] f);
    return {{(XLEN-FIELD_W-1){1'b0}}, f, 1'b0};
  endfunction

  logic [XLEN-1:0] ind_tgt;

  generate
    if (ALIGN_PC_SRC) begin : g_align
      assign ind_tgt = src_is_pc ? {rm_val[XLEN-1:2], 2'b00}
                                 : {rm_val[XLEN-1:1], 1'b0};
    end else begin : g_plain
      logic unused_src;
      assign unused_src = src_is_pc;
      assign ind_tgt = {rm_val[XLEN-1:1], 1'b0};
    end
  endgenerate

  always_comb begin
    pc_n    = pc;
    lr_n    = lr;
    pc_we   = 1'b0;
    lr_we   = 1'b0;
    mode    = 1'b0;
    mode_we = 1'b0;
    case (kind)
      BK_COND: begin
        pc_n  = pc + off_short(field[SHORT_W-1:0]);
        pc_we = 1'b1;
      end
      BK_JUMP: begin
        pc_n  = pc + off_jump(field);
        pc_we = 1'b1;
      end
      BK_CALL_HI: begin
        lr_n  = pc + off_call_hi(field);
        lr_we = 1'b1;
      end
      BK_CALL_LO: begin
        pc_n  = lr + off_call_lo(field);
        lr_n  = pc - {{(XLEN-1){1'b0}}, 1'b1};
        pc_we = 1'b1;
        lr_we = 1'b1;
      end
      BK_INDIRECT: begin
        pc_n    = ind_tgt;
        pc_we   = 1'b1;
        mode    = rm_val[0];
        mode_we = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/compact_branch_gen.sv
module compact_branch_gen
  import cbt_pkg::*;
#(
  parameter int XLEN = 32,
  parameter bit ALIGN_PC_SRC = 1'b1
) (
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   lr_i,
  input  logic [XLEN-1:0]   rm_val_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic              cond_pass_i,
  output logic [XLEN-1:0]   pc_o,
  output logic              pc_we_o,
  output logic [XLEN-1:0]   lr_o,
  output logic              lr_we_o,
  output logic              mode_o,
  output logic              mode_we_o
);
  br_kind_e kind;
  logic     src_is_pc;

  cbt_decode u_dec (
    .op_hi     (insn_i[INSN_W-1:3]),
    .cond_ok   (cond_pass_i),
    .kind      (kind),
    .src_is_pc (src_is_pc)
  );

  cbt_target #(.XLEN(XLEN), .ALIGN_PC_SRC(ALIGN_PC_SRC)) u_tgt (
    .kind      (kind),
    .src_is_pc (src_is_pc),
    .field     (insn_i[FIELD_W-1:0]),
    .pc        (pc_i),
    .lr        (lr_i),
    .rm_val    (rm_val_i),
    .pc_n      (pc_o),
    .pc_we     (pc_we_o),
    .lr_n      (lr_o),
    .lr_we     (lr_we_o),
    .mode      (mode_o),
    .mode_we   (mode_we_o)
  );
endmodule

// File: rtl/cbt_checker.sv
module cbt_checker
  import cbt_pkg::*;
#(
  parameter int XLEN = 32,
  parameter bit ALIGN_PC_SRC = 1'b1
) (
  input logic [XLEN-1:0]   pc_i,
  input logic [XLEN-1:0]   lr_i,
  input logic [INSN_W-1:0] insn_i,
  input br_kind_e          kind,
  input logic [XLEN-1:0]   pc_o,
  input logic              pc_we_o,
  input logic [XLEN-1:0]   lr_o,
  input logic              lr_we_o,
  input logic              mode_o,
  input logic              mode_we_o
);
  always_comb begin
    if (!$isunknown(insn_i)) begin
      a_r8_mode_only_indirect: assert (!mode_we_o || kind == BK_INDIRECT);
      a_r8_mode_quiet: assert (mode_we_o || !mode_o);
      a_r6_even_target: assert (!mode_we_o || (pc_we_o && !pc_o[0]));
      a_r7_pc_src_word: assert (!(ALIGN_PC_SRC && mode_we_o && insn_i[6:3] == PC_REG_IDX)
                                || pc_o[1:0] == 2'b00);
      a_r2_pc_hold: assert (pc_we_o || pc_o == pc_i);
      a_r2_lr_hold: assert (lr_we_o || lr_o == lr_i);
      a_r4_call_hi_keeps_pc: assert (kind != BK_CALL_HI || (lr_we_o && !pc_we_o));
      a_r5_call_lo_both: assert (kind != BK_CALL_LO || (lr_we_o && pc_we_o));
    end
  end
endmodule

bind compact_branch_gen cbt_checker #(.XLEN(XLEN), .ALIGN_PC_SRC(ALIGN_PC_SRC)) u_chk (
  .pc_i      (pc_i),
  .lr_i      (lr_i),
  .insn_i    (insn_i),
  .kind      (kind),
  .pc_o      (pc_o),
  .pc_we_o   (pc_we_o),
  .lr_o      (lr_o),
  .lr_we_o   (lr_we_o),
  .mode_o    (mode_o),
  .mode_we_o (mode_we_o)
);

// File: tb/compact_branch_gen_test.sv
module compact_branch_gen_test;
  typedef struct {
    string       tag;
    logic [31:0] pc;
    logic        pc_we;
    logic [31:0] lr;
    logic        lr_we;
    logic        mode;
    logic        mode_we;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] pc_i = '0, lr_i = '0, rm_val_i = '0;
  logic [15:0] insn_i = '0;
  logic cond_pass_i = 1'b0;
  logic [31:0] pc_o, lr_o;
  logic pc_we_o, lr_we_o, mode_o, mode_we_o;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;
  exp_t sb[$];

  always #10 clk = ~clk;

  compact_branch_gen uut (
    .pc_i(pc_i), .lr_i(lr_i), .rm_val_i(rm_val_i), .insn_i(insn_i),
    .cond_pass_i(cond_pass_i), .pc_o(pc_o), .pc_we_o(pc_we_o),
    .lr_o(lr_o), .lr_we_o(lr_we_o), .mode_o(mode_o), .mode_we_o(mode_we_o)
  );

  function automatic int sx(input int v, input int bits);
    if (v >= (1 << (bits - 1))) return v - (1 << bits);
    return v;
  endfunction

  function automatic exp_t quiet(input string tag, input logic [31:0] pc, input logic [31:0] lr);
    exp_t e;
    e.tag = tag; e.pc = pc; e.pc_we = 0; e.lr = lr; e.lr_we = 0; e.mode = 0; e.mode_we = 0;
    return e;
  endfunction

  task automatic drive(input string tag, input logic [31:0] pc, input logic [31:0] lr,
                       input logic [31:0] rv, input logic [15:0] ins, input logic ok,
                       input exp_t e);
    @(negedge clk);
    pc_i = pc; lr_i = lr; rm_val_i = rv; insn_i = ins; cond_pass_i = ok;
    e.tag = tag;
    sb.push_back(e);
  endtask

  always @(posedge clk) begin
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_tests++;
      if (pc_o !== e.pc || pc_we_o !== e.pc_we || lr_o !== e.lr || lr_we_o !== e.lr_we ||
          mode_o !== e.mode || mode_we_o !== e.mode_we) begin
        n_fail++;
        $display("FAIL %s: got pc=%h/%b lr=%h/%b mode=%b/%b exp pc=%h/%b lr=%h/%b mode=%b/%b",
                 e.tag, pc_o, pc_we_o, lr_o, lr_we_o, mode_o, mode_we_o,
                 e.pc, e.pc_we, e.lr, e.lr_we, e.mode, e.mode_we);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    exp_t e;
    logic [31:0] p, l;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: idle halfword, no writes
    drive("R8 idle", 32'h100, 32'h200, 32'h1, 16'h0000, 1'b1, quiet("", 32'h100, 32'h200));
    drive("R8 add form", 32'h104, 32'h208, 32'h3, 16'h4483, 1'b1, quiet("", 32'h104, 32'h208));

    // R1: conditional, positive and negative offsets
    p = 32'h1000;
    e = quiet("", p, 32'h55); e.pc = p + 32'(sx(8'h10, 8) * 2); e.pc_we = 1;
    drive("R1 cond fwd", p, 32'h55, 0, {4'hD, 4'h0, 8'h10}, 1'b1, e);
    e = quiet("", p, 32'h55); e.pc = p + 32'(sx(8'hFE, 8) * 2); e.pc_we = 1;
    drive("R1 cond back", p, 32'h55, 0, {4'hD, 4'hB, 8'hFE}, 1'b1, e);
    e = quiet("", p, 32'h55); e.pc = p + 32'(sx(8'h80, 8) * 2); e.pc_we = 1;
    drive("R1 cond min", p, 32'h55, 0, {4'hD, 4'hD, 8'h80}, 1'b1, e);

    // R2: failed condition and reserved codes
    drive("R2 cond fail", p, 32'h55, 0, {4'hD, 4'h1, 8'h10}, 1'b0, quiet("", p, 32'h55));
    drive("R2 code 1111", p, 32'h55, 0, {4'hD, 4'hF, 8'h10}, 1'b1, quiet("", p, 32'h55));
    drive("R2 code 1110", p, 32'h55, 0, {4'hD, 4'hE, 8'h7F}, 1'b1, quiet("", p, 32'h55));

    // R3: unconditional
    e = quiet("", p, 32'h55); e.pc = p + 32'(sx(11'h7FF, 11) * 2); e.pc_we = 1;
    drive("R3 jump -1", p, 32'h55, 0, {5'b11100, 11'h7FF}, 1'b0, e);
    e = quiet("", p, 32'h55); e.pc = p + 32'(sx(11'h3FF, 11) * 2); e.pc_we = 1;
    drive("R3 jump max", p, 32'h55, 0, {5'b11100, 11'h3FF}, 1'b0, e);

    // R4: first call half
    p = 32'h0800_0000;
    e = quiet("", p, 32'h77); e.lr = p + 32'(sx(11'h400, 11) * 4096); e.lr_we = 1;
    drive("R4 call hi neg", p, 32'h77, 0, {5'b11110, 11'h400}, 1'b0, e);
    e = quiet("", p, 32'h77); e.lr = p + 32'(sx(11'h001, 11) * 4096); e.lr_we = 1;
    drive("R4 call hi pos", p, 32'h77, 0, {5'b11110, 11'h001}, 1'b0, e);

    // R5: second call half
    l = 32'h0800_1000;
    e = quiet("", p, l); e.pc = l + 32'(11'h7FE * 2); e.pc_we = 1; e.lr = p - 1; e.lr_we = 1;
    drive("R5 call lo", p, l, 0, {5'b11111, 11'h7FE}, 1'b0, e);

    // R6: indirect, low register
    e = quiet("", p, l); e.pc = 32'h0800_0100; e.pc_we = 1; e.mode = 1; e.mode_we = 1;
    drive("R6 ind odd", p, l, 32'h0800_0101, {9'b010001110, 4'd3, 3'b000}, 1'b0, e);
    e = quiet("", p, l); e.pc = 32'h0800_0202; e.pc_we = 1; e.mode = 0; e.mode_we = 1;
    drive("R6 ind even", p, l, 32'h0800_0202, {9'b010001110, 4'd9, 3'b000}, 1'b0, e);
    e = quiet("", p, l); e.pc = 32'h0800_0302; e.pc_we = 1; e.mode = 1; e.mode_we = 1;
    drive("R7 ref low reg", p, l, 32'h0800_0303, {9'b010001110, 4'd14, 3'b000}, 1'b0, e);

    // R7: PC as source clears bit 1 too
    e = quiet("", p, l); e.pc = 32'h0800_0304; e.pc_we = 1; e.mode = 1; e.mode_we = 1;
    drive("R7 pc src odd", p, l, 32'h0800_0307, {9'b010001110, 4'd15, 3'b000}, 1'b0, e);
    e = quiet("", p, l); e.pc = 32'h0800_0004; e.pc_we = 1; e.mode = 0; e.mode_we = 1;
    drive("R7 pc src even", p, l, 32'h0800_0006, {9'b010001110, 4'd15, 3'b000}, 1'b0, e);

    // R9: wrap-around
    p = 32'hFFFF_FFFE;
    e = quiet("", p, 32'h9); e.pc = 32'h0000_0002; e.pc_we = 1;
    drive("R9 cond wrap", p, 32'h9, 0, {4'hD, 4'h2, 8'h02}, 1'b1, e);
    p = 32'h0000_0002;
    e = quiet("", p, 32'h9); e.pc = 32'hFFFF_F802; e.pc_we = 1;
    drive("R9 jump wrap", p, 32'h9, 0, {5'b11100, 11'h400}, 1'b0, e);
    l = 32'hFFFF_FF00;
    e = quiet("", p, l); e.pc = 32'h0000_06FC; e.pc_we = 1; e.lr = 32'h0000_0001; e.lr_we = 1;
    drive("R9 call lo wrap", p, l, 0, {5'b11111, 11'h3FE}, 1'b0, e);
    e = quiet("", 32'h0, 32'h9); e.pc = 32'h0; e.lr = 32'hFFFF_FFFF; e.lr_we = 1; e.pc_we = 1;
    e.pc = 32'h9;
    drive("R9 lr borrow", 32'h0, 32'h9, 0, {5'b11111, 11'h000}, 1'b0, e);

    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule